// File: doc/BRIEF.md
# I2C Target Register Bank

This block is a serial two-wire target that gives an external I2C controller access to a bank of 26 byte-wide control registers. It samples SCL and SDA on the system clock, recognises bus START, repeated START and STOP conditions, and shifts each byte in MSB first. It answers only to one fixed 7-bit device identifier. Every accepted byte is acknowledged by pulling SDA low. Read data is returned through an open-drain style enable: `sda_oe` high means "pull SDA low", and the line is never actively driven high.

A single byte pointer is shared by reads and writes. A write transaction carries the device byte, a word address that loads the pointer, and then data bytes that are stored at the pointer. A read transaction returns bytes from the pointer location. Because the pointer survives between transactions, a read can start where the last access stopped (current-address read). It can also be placed first by a write preamble followed by a repeated START (random read). The pointer steps by one per data byte and wraps from the last register back to register 0.

A combinational host-side read port lets the surrounding logic observe any register directly. Inside the chip, the block sits between the pad logic and the logic that consumes the control bytes.

Top module: `i2c_regbank_target`

## Requirements
- R1: START is SDA falling while SCL is high and STOP is SDA rising while SCL is high. After a STOP the block is idle and `sda_oe` is low.
- R2: The first byte after a START carries the identifier in bits 7..1 and the direction in bit 0 (1 = read, 0 = write). When bits 7..1 equal binary 1101111, the block holds `sda_oe` high through the ninth SCL high phase (ACK).
- R3: When the identifier does not match, the block gives no ACK. It ignores every later byte until the next START, and neither the registers nor the pointer change.
- R4: In a write, the second byte is a word address that loads the pointer. Each following data byte is written to the register at the pointer, after which the pointer advances by one. The block acknowledges every one of these bytes.
- R5: A word address above 0x19 is not acknowledged. The rest of that transaction is ignored, and the registers and the pointer keep their values.
- R6: After reset the pointer is 0 and register n holds the value n. A read with no prior write therefore returns 0x00, 0x01, 0x02, … in that order.
- R7: A random read is a write of the device byte and word address, then a repeated START and the device byte with bit 0 set. The data returned starts at that word address.
- R8: The pointer wraps from 0x19 to 0x00, both in a read burst and in a write burst.
- R9: The block sends another byte each time the controller ACKs the previous one. After a controller NACK it releases SDA, drives nothing more until the next START, and its pointer points past the last byte sent.
- R10: Read bits go out MSB first. `sda_oe` changes only while SCL is low.
- R11: A STOP or START in the middle of a byte abandons that byte. The partial byte is not written and the pointer keeps its last value.
- R12: `host_rdata` shows the register selected by `host_addr` in the same cycle, and reads 0 when `host_addr` is above 0x19.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| scl_i | input | 1 | Serial clock line as seen at the pad |
| sda_i | input | 1 | Serial data line as seen at the pad |
| sda_oe | output | 1 | High pulls SDA low (ACK or a 0 read bit) |
| host_addr | input | 5 | Register index for the host read port |
| host_rdata | output | 8 | Contents of the selected register |

## Verification
The bench covers the following corner cases:
- **Pointer wrap.** Bursts cross register 0x19 in both directions. A pointer that overran would read back zeros or corrupt a register that does not exist.
- **Pointer retention.** A current-address read follows a mismatched identifier, an out-of-range word address, a NACK-ended burst, and transfers cut short by STOP or by START. Each of these exposes a design that moves or clears the pointer when it should not.
- **Release after NACK.** Extra clocks after the controller's NACK must read back all ones. A design still sending would show its next byte.
- **SDA timing.** A monitor watches for any change of `sda_oe` while SCL is high. A design that did this would create false START or STOP conditions on the bus.

// File: rtl/i2c_tgt_pkg.sv
// Package: shared types for the I2C target register bank.
// Assumes bytes are eight bits wide on the serial bus.
package i2c_tgt_pkg;
    localparam int BYTE_W = 8;

    typedef enum logic [2:0] {
        ST_IDLE,   // waiting for START
        ST_DEV,    // shifting in device byte
        ST_WADDR,  // shifting in word address
        ST_WDATA,  // shifting in write data
        ST_ACK,    // driving ACK in ninth clock
        ST_TX,     // shifting out read data
        ST_MACK    // sampling controller ACK/NACK
    } tgt_state_e;
endpackage

// File: rtl/i2c_line_sampler.sv
// Module: i2c_line_sampler
// Synchronises SCL and SDA into the clk domain and derives SCL edges and
// bus START/STOP conditions from the synchronised lines.
// Assumes: the bus is idle high at reset and each line is stable for more
// than SYNC_STAGES+1 clocks between transitions.
module i2c_line_sampler #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_i,
    input  logic sda_i,
    output logic scl_s,
    output logic sda_s,
    output logic scl_rise,
    output logic scl_fall,
    output logic start_det,
    output logic stop_det
);
    logic [SYNC_STAGES-1:0] scl_pipe;
    logic [SYNC_STAGES-1:0] sda_pipe;
    logic                   scl_q;
    logic                   sda_q;

    // Purpose: metastability filter chain for both bus lines.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            scl_pipe <= '1;
            sda_pipe <= '1;
        end else begin
            scl_pipe <= {scl_pipe[SYNC_STAGES-2:0], scl_i};
            sda_pipe <= {sda_pipe[SYNC_STAGES-2:0], sda_i};
        end
    end

    assign scl_s = scl_pipe[SYNC_STAGES-1];
    assign sda_s = sda_pipe[SYNC_STAGES-1];

    // Purpose: one-cycle history of the synchronised lines for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            scl_q <= 1'b1;
            sda_q <= 1'b1;
        end else begin
            scl_q <= scl_s;
            sda_q <= sda_s;
        end
    end

    // Purpose: edge and bus-condition decode.
    always_comb begin
        scl_rise  = scl_s & ~scl_q;
        scl_fall  = ~scl_s & scl_q;
        start_det = scl_s & scl_q & sda_q & ~sda_s;
        stop_det  = scl_s & scl_q & ~sda_q & sda_s;
    end
endmodule

// File: rtl/i2c_reg_array.sv
// Module: i2c_reg_array
// Bank of NUM_REGS byte registers with one synchronous write port and two
// combinational read ports. Register n resets to the value n.
// Assumes: NUM_REGS fits in AW address bits; out-of-range reads return 0.
module i2c_reg_array
    import i2c_tgt_pkg::*;
#(
    parameter  int NUM_REGS = 26,
    localparam int AW       = $clog2(NUM_REGS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [AW-1:0]     wr_addr,
    input  logic [BYTE_W-1:0] wr_data,
    input  logic [AW-1:0]     rd_addr_a,
    output logic [BYTE_W-1:0] rd_data_a,
    input  logic [AW-1:0]     rd_addr_b,
    output logic [BYTE_W-1:0] rd_data_b
);
    logic [NUM_REGS*BYTE_W-1:0] flat;

    for (genvar g = 0; g < NUM_REGS; g++) begin : g_reg
        logic [BYTE_W-1:0] q;
        // Purpose: storage for register g, loaded on a matching write.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                q <= BYTE_W'(g);
            end else if (wr_en && (wr_addr == AW'(g))) begin
                q <= wr_data;
            end
        end
        assign flat[g*BYTE_W +: BYTE_W] = q;
    end

    // Purpose: read port A (protocol side) selection.
    always_comb begin
        rd_data_a = '0;
        for (int i = 0; i < NUM_REGS; i++) begin
            if (rd_addr_a == AW'(i)) rd_data_a = flat[i*BYTE_W +: BYTE_W];
        end
    end

    // Purpose: read port B (host side) selection.
    always_comb begin
        rd_data_b = '0;
        for (int i = 0; i < NUM_REGS; i++) begin
            if (rd_addr_b == AW'(i)) rd_data_b = flat[i*BYTE_W +: BYTE_W];
        end
    end
endmodule

// File: rtl/i2c_target_fsm.sv
// Module: i2c_target_fsm
// Byte-level protocol engine: shifts device, word-address and data bytes,
// generates ACK, streams read data, and owns the shared register pointer.
// Assumes: edge and bus-condition strobes come from i2c_line_sampler and
// read data for the current pointer is available combinationally.
module i2c_target_fsm
    import i2c_tgt_pkg::*;
#(
    parameter  logic [6:0] DEV_ID   = 7'b1101111,
    parameter  int         NUM_REGS = 26,
    localparam int         AW       = $clog2(NUM_REGS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              scl_rise,
    input  logic              scl_fall,
    input  logic              sda_s,
    input  logic              start_det,
    input  logic              stop_det,
    input  logic [BYTE_W-1:0] rd_data,
    output logic              sda_oe,
    output logic [AW-1:0]     ptr,
    output logic              ptr_load,
    output logic              wr_en,
    output logic [AW-1:0]     wr_addr,
    output logic [BYTE_W-1:0] wr_data
);
    localparam logic [AW-1:0]     LAST_PTR  = AW'(NUM_REGS - 1);
    localparam logic [BYTE_W-1:0] LAST_BYTE = BYTE_W'(NUM_REGS - 1);

    tgt_state_e        state;
    tgt_state_e        nxt;
    logic [2:0]        cnt;
    logic              got8;
    logic              mack;
    logic [BYTE_W-1:0] shreg;
    logic [BYTE_W-1:0] txsh;

    function automatic logic [AW-1:0] ptr_step(input logic [AW-1:0] p);
        return (p == LAST_PTR) ? '0 : p + AW'(1);
    endfunction

    // Purpose: protocol sequencing, pointer update and SDA pull control.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state    <= ST_IDLE;
            nxt      <= ST_IDLE;
            cnt      <= '0;
            got8     <= 1'b0;
            mack     <= 1'b0;
            shreg    <= '0;
            txsh     <= '0;
            sda_oe   <= 1'b0;
            ptr      <= '0;
            ptr_load <= 1'b0;
            wr_en    <= 1'b0;
            wr_addr  <= '0;
            wr_data  <= '0;
        end else begin
            wr_en    <= 1'b0;
            ptr_load <= 1'b0;
            if (start_det) begin
                state  <= ST_DEV;
                cnt    <= '0;
                got8   <= 1'b0;
                sda_oe <= 1'b0;
            end else if (stop_det) begin
                state  <= ST_IDLE;
                cnt    <= '0;
                got8   <= 1'b0;
                sda_oe <= 1'b0;
            end else begin
                case (state)
                    ST_DEV, ST_WADDR, ST_WDATA: begin
                        if (scl_rise) begin
                            shreg <= {shreg[BYTE_W-2:0], sda_s};
                            cnt   <= cnt + 3'd1;
                            if (cnt == 3'd7) got8 <= 1'b1;
                        end else if (scl_fall && got8) begin
                            got8 <= 1'b0;
                            cnt  <= '0;
                            if (state == ST_DEV) begin
                                if (shreg[7:1] == DEV_ID) begin
                                    sda_oe <= 1'b1;
                                    state  <= ST_ACK;
                                    nxt    <= shreg[0] ? ST_TX : ST_WADDR;
                                end else begin
                                    state <= ST_IDLE;
                                end
                            end else if (state == ST_WADDR) begin
                                if (shreg <= LAST_BYTE) begin
                                    ptr      <= shreg[AW-1:0];
                                    ptr_load <= 1'b1;
                                    sda_oe   <= 1'b1;
                                    state    <= ST_ACK;
                                    nxt      <= ST_WDATA;
                                end else begin
                                    state <= ST_IDLE;
                                end
                            end else begin
                                wr_en   <= 1'b1;
                                wr_addr <= ptr;
                                wr_data <= shreg;
                                ptr     <= ptr_step(ptr);
                                sda_oe  <= 1'b1;
                                state   <= ST_ACK;
                                nxt     <= ST_WDATA;
                            end
                        end
                    end
                    ST_ACK: begin
                        if (scl_fall) begin
                            cnt <= '0;
                            if (nxt == ST_TX) begin
                                txsh   <= rd_data;
                                sda_oe <= ~rd_data[BYTE_W-1];
                                state  <= ST_TX;
                            end else begin
                                sda_oe <= 1'b0;
                                state  <= nxt;
                            end
                        end
                    end
                    ST_TX: begin
                        if (scl_fall) begin
                            if (cnt == 3'd7) begin
                                sda_oe <= 1'b0;
                                ptr    <= ptr_step(ptr);
                                state  <= ST_MACK;
                            end else begin
                                cnt    <= cnt + 3'd1;
                                txsh   <= {txsh[BYTE_W-2:0], 1'b0};
                                sda_oe <= ~txsh[BYTE_W-2];
                            end
                        end
                    end
                    ST_MACK: begin
                        if (scl_rise) begin
                            mack <= ~sda_s;
                        end else if (scl_fall) begin
                            if (mack) begin
                                txsh   <= rd_data;
                                sda_oe <= ~rd_data[BYTE_W-1];
                                cnt    <= '0;
                                state  <= ST_TX;
                            end else begin
                                state <= ST_IDLE;
                            end
                        end
                    end
                    default: state <= ST_IDLE;
                endcase
            end
        end
    end
endmodule

// File: rtl/i2c_regbank_target.sv
// Module: i2c_regbank_target (top)
// I2C target exposing NUM_REGS byte registers behind a fixed 7-bit
// identifier, with a shared auto-incrementing pointer and a host read port.
// Assumes: sda_oe drives an open-drain pad (high = pull low); SCL and SDA
// are asynchronous to clk and much slower than it.
module i2c_regbank_target
    import i2c_tgt_pkg::*;
#(
    parameter  logic [6:0] DEV_ID      = 7'b1101111,
    parameter  int         NUM_REGS    = 26,
    parameter  int         SYNC_STAGES = 2,
    localparam int         AW          = $clog2(NUM_REGS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              scl_i,
    input  logic              sda_i,
    output logic              sda_oe,
    input  logic [AW-1:0]     host_addr,
    output logic [BYTE_W-1:0] host_rdata
);
    logic              scl_s_w;
    logic              sda_s_w;
    logic              scl_rise_w;
    logic              scl_fall_w;
    logic              start_w;
    logic              stop_w;
    logic [AW-1:0]     ptr_w;
    logic              ptr_load_w;
    logic              wr_en_w;
    logic [AW-1:0]     wr_addr_w;
    logic [BYTE_W-1:0] wr_data_w;
    logic [BYTE_W-1:0] rd_data_w;

    i2c_line_sampler #(
        .SYNC_STAGES (SYNC_STAGES)
    ) u_sampler (
        .clk       (clk),
        .rst_n     (rst_n),
        .scl_i     (scl_i),
        .sda_i     (sda_i),
        .scl_s     (scl_s_w),
        .sda_s     (sda_s_w),
        .scl_rise  (scl_rise_w),
        .scl_fall  (scl_fall_w),
        .start_det (start_w),
        .stop_det  (stop_w)
    );

    i2c_target_fsm #(
        .DEV_ID   (DEV_ID),
        .NUM_REGS (NUM_REGS)
    ) u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .scl_rise  (scl_rise_w),
        .scl_fall  (scl_fall_w),
        .sda_s     (sda_s_w),
        .start_det (start_w),
        .stop_det  (stop_w),
        .rd_data   (rd_data_w),
        .sda_oe    (sda_oe),
        .ptr       (ptr_w),
        .ptr_load  (ptr_load_w),
        .wr_en     (wr_en_w),
        .wr_addr   (wr_addr_w),
        .wr_data   (wr_data_w)
    );

    i2c_reg_array #(
        .NUM_REGS (NUM_REGS)
    ) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (wr_en_w),
        .wr_addr   (wr_addr_w),
        .wr_data   (wr_data_w),
        .rd_addr_a (ptr_w),
        .rd_data_a (rd_data_w),
        .rd_addr_b (host_addr),
        .rd_data_b (host_rdata)
    );
endmodule

// File: rtl/i2c_regbank_target_chk.sv
// Module: i2c_regbank_target_chk
// Protocol and pointer properties for i2c_regbank_target, attached by bind.
// Assumes: signals are sampled on clk with synchronous active-low reset.
module i2c_regbank_target_chk #(
    parameter  int NUM_REGS = 26,
    localparam int AW       = $clog2(NUM_REGS)
) (
    input logic          clk,
    input logic          rst_n,
    input logic          sda_oe,
    input logic          scl_s,
    input logic          start_det,
    input logic          stop_det,
    input logic          ptr_load,
    input logic          wr_en,
    input logic [AW-1:0] ptr,
    input logic [AW-1:0] wr_addr
);
    localparam logic [AW-1:0] LAST_PTR = AW'(NUM_REGS - 1);

    logic past_ok;

    // Purpose: marks cycles that have a valid previous cycle after reset.
    always_ff @(posedge clk) begin
        if (!rst_n) past_ok <= 1'b0;
        else        past_ok <= 1'b1;
    end

    // R10: the pull-down may only move while SCL is low
    p_oe_scl_low_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (past_ok && (sda_oe != $past(sda_oe)) && !$past(start_det) && !$past(stop_det))
        |-> !$past(scl_s));

    // R1: a STOP always leaves SDA released
    p_stop_release_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (past_ok && $past(stop_det)) |-> !sda_oe);

    // R8: pointer never leaves the register range
    p_ptr_range_r8: assert property (@(posedge clk) disable iff (!rst_n)
        ptr <= LAST_PTR);

    // R8: any pointer move that is not a load is a +1 step with wrap
    p_ptr_step_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (past_ok && (ptr != $past(ptr)) && !ptr_load)
        |-> (ptr == (($past(ptr) == LAST_PTR) ? '0 : $past(ptr) + AW'(1))));

    // R4: each register write targets the pointer value before the write
    p_write_at_ptr_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (past_ok && wr_en) |-> (wr_addr == $past(ptr)));
endmodule

bind i2c_regbank_target i2c_regbank_target_chk #(
    .NUM_REGS (NUM_REGS)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .sda_oe    (sda_oe),
    .scl_s     (scl_s_w),
    .start_det (start_w),
    .stop_det  (stop_w),
    .ptr_load  (ptr_load_w),
    .wr_en     (wr_en_w),
    .ptr       (ptr_w),
    .wr_addr   (wr_addr_w)
);

// File: tb/i2c_regbank_target_tb.sv
// Scoreboard bench: transaction tasks push expected read bytes into a
// queue, a monitor pops and compares them against bytes seen on SDA.
module i2c_regbank_target_tb;
    localparam int         Q  = 5;
    localparam logic [6:0] ID = 7'b1101111;

    typedef struct {
        logic [7:0] d;
        string      tag;
    } exp_t;

    logic       clk   = 1'b0;
    logic       rst_n = 1'b0;
    logic       scl   = 1'b1;
    logic       m_sda = 1'b1;
    logic [4:0] host_addr = '0;
    logic [7:0] host_rdata;
    logic       sda_oe;
    wire        sda_line = m_sda & ~sda_oe;

    int         n_chk = 0;
    int         n_fail = 0;
    int         r10_bad = 0;
    int         mptr = 0;
    logic [7:0] mdl [26];
    logic [7:0] wd [4];
    exp_t       exp_q [$];
    logic [7:0] obs_q [$];
    logic       scl_prev = 1'b1;
    logic       oe_prev = 1'b0;
    bit         done = 1'b0;

    always #4 clk = ~clk;

    i2c_regbank_target u_dut (
        .clk        (clk),
        .rst_n      (rst_n),
        .scl_i      (scl),
        .sda_i      (sda_line),
        .sda_oe     (sda_oe),
        .host_addr  (host_addr),
        .host_rdata (host_rdata)
    );

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic check(input bit ok, input string req, input logic [7:0] act,
                         input logic [7:0] exp, input string what);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual 0x%02h expected 0x%02h", req, what, act, exp);
        end
    endtask

    function automatic int nxt_ptr(input int p);
        return (p == 25) ? 0 : p + 1;
    endfunction

    // Monitor: compare each observed read byte with the next expected one
    always @(negedge clk) begin
        if (obs_q.size() > 0) begin
            exp_t       e;
            logic [7:0] o;
            o = obs_q.pop_front();
            if (exp_q.size() == 0) begin
                check(1'b0, "R9", o, 8'h00, "unexpected read byte");
            end else begin
                e = exp_q.pop_front();
                check(o === e.d, e.tag, o, e.d, "read byte");
            end
        end
    end

    // R10 watcher: SDA pull must not move while SCL is high
    always @(negedge clk) begin
        if (rst_n && scl && scl_prev && (sda_oe != oe_prev)) r10_bad++;
        scl_prev <= scl;
        oe_prev  <= sda_oe;
    end

    task automatic i2c_start();
        m_sda = 1'b1; tick(Q);
        scl   = 1'b1; tick(Q);
        m_sda = 1'b0; tick(Q);
        scl   = 1'b0; tick(Q);
    endtask

    task automatic i2c_stop();
        m_sda = 1'b0; tick(Q);
        scl   = 1'b1; tick(Q);
        m_sda = 1'b1; tick(Q);
    endtask

    task automatic send_bits(input logic [7:0] b, input int n);
        for (int i = 0; i < n; i++) begin
            m_sda = b[7-i]; tick(Q);
            scl = 1'b1; tick(2*Q);
            scl = 1'b0; tick(Q);
        end
    endtask

    task automatic wbyte(input logic [7:0] b, output bit ack_n);
        send_bits(b, 8);
        m_sda = 1'b1; tick(Q);
        scl = 1'b1; tick(Q);
        ack_n = sda_line; tick(Q);
        scl = 1'b0; tick(Q);
    endtask

    task automatic rbyte(input bit give_ack);
        logic [7:0] d;
        m_sda = 1'b1;
        for (int i = 0; i < 8; i++) begin
            tick(Q); scl = 1'b1;
            tick(Q); d[7-i] = sda_line;
            tick(Q); scl = 1'b0;
            tick(Q);
        end
        m_sda = ~give_ack; tick(Q);
        scl = 1'b1; tick(2*Q);
        scl = 1'b0; tick(Q);
        m_sda = 1'b1;
        obs_q.push_back(d);
    endtask

    task automatic push_exp(input logic [7:0] d, input string tag);
        exp_t e;
        e.d = d;
        e.tag = tag;
        exp_q.push_back(e);
    endtask

    task automatic do_write(input logic [7:0] addr, input int n,
                            input logic [7:0] data [4], input string tag);
        bit a;
        i2c_start();
        wbyte({ID, 1'b0}, a); check(a == 1'b0, "R2", {7'b0, a}, 8'h00, "device ack (write)");
        wbyte(addr, a);       check(a == 1'b0, "R4", {7'b0, a}, 8'h00, "word address ack");
        mptr = int'(addr);
        for (int i = 0; i < n; i++) begin
            wbyte(data[i], a); check(a == 1'b0, tag, {7'b0, a}, 8'h00, "data ack");
            mdl[mptr] = data[i];
            mptr = nxt_ptr(mptr);
        end
        i2c_stop();
    endtask

    task automatic do_read(input bit rnd, input logic [7:0] addr, input int n,
                           input string tag);
        bit a;
        i2c_start();
        if (rnd) begin
            wbyte({ID, 1'b0}, a); check(a == 1'b0, "R7", {7'b0, a}, 8'h00, "preamble device ack");
            wbyte(addr, a);       check(a == 1'b0, "R7", {7'b0, a}, 8'h00, "preamble address ack");
            mptr = int'(addr);
            i2c_start();
        end
        wbyte({ID, 1'b1}, a); check(a == 1'b0, "R2", {7'b0, a}, 8'h00, "device ack (read)");
        for (int i = 0; i < n; i++) begin
            push_exp(mdl[mptr], tag);
            mptr = nxt_ptr(mptr);
            rbyte(i < n - 1);
        end
        i2c_stop();
    endtask

    task automatic host_chk(input logic [4:0] addr, input logic [7:0] exp, input string tag);
        host_addr = addr;
        tick(1);
        check(host_rdata === exp, tag, host_rdata, exp, "host port");
    endtask

    task automatic finish_tb();
        if (!done) begin
            done = 1'b1;
            $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
            $finish;
        end
    endtask

    // Watchdog
    initial begin
        repeat (150000) @(posedge clk);
        check(1'b0, "R1", 8'h00, 8'h01, "watchdog expired");
        finish_tb();
    end

    initial begin
        bit a;
        for (int i = 0; i < 26; i++) mdl[i] = 8'(i);
        tick(5);
        rst_n = 1'b1;
        tick(5);

        // R1 / R6 / R12: reset state
        check(sda_oe == 1'b0, "R1", {7'b0, sda_oe}, 8'h00, "SDA released after reset");
        host_chk(5'd0, 8'h00, "R6");
        host_chk(5'd25, 8'h19, "R6");
        host_chk(5'd30, 8'h00, "R12");

        // R6: current-address read from reset pointer
        do_read(1'b0, 8'h00, 3, "R6");

        // R3: wrong identifier, following bytes ignored
        i2c_start();
        wbyte({7'b1101110, 1'b0}, a); check(a == 1'b1, "R3", {7'b0, a}, 8'h01, "no ack on mismatch");
        wbyte(8'h05, a);              check(a == 1'b1, "R3", {7'b0, a}, 8'h01, "ignored byte");
        wbyte(8'h77, a);              check(a == 1'b1, "R3", {7'b0, a}, 8'h01, "ignored byte");
        i2c_stop();
        host_chk(5'd5, 8'h05, "R3");
        do_read(1'b0, 8'h00, 1, "R3");

        // R4 / R12: burst write then host readback
        wd = '{8'h11, 8'h22, 8'h33, 8'h00};
        do_write(8'h04, 3, wd, "R4");
        check(sda_oe == 1'b0, "R1", {7'b0, sda_oe}, 8'h00, "SDA released after STOP");
        host_chk(5'd4, 8'h11, "R12");
        host_chk(5'd5, 8'h22, "R4");
        host_chk(5'd6, 8'h33, "R4");
        do_read(1'b0, 8'h00, 1, "R4");

        // R7: random read
        do_read(1'b1, 8'h05, 2, "R7");

        // R9: after NACK the line stays released
        i2c_start();
        wbyte({ID, 1'b1}, a); check(a == 1'b0, "R2", {7'b0, a}, 8'h00, "device ack (read)");
        push_exp(mdl[mptr], "R9"); mptr = nxt_ptr(mptr);
        rbyte(1'b0);
        push_exp(8'hFF, "R9");
        rbyte(1'b0);
        i2c_stop();
        do_read(1'b0, 8'h00, 1, "R9");

        // R8: read wrap across last register
        do_read(1'b1, 8'h18, 4, "R8");

        // R8: write wrap across last register
        wd = '{8'hA5, 8'h5A, 8'h00, 8'h00};
        do_write(8'h19, 2, wd, "R8");
        host_chk(5'd25, 8'hA5, "R8");
        host_chk(5'd0, 8'h5A, "R8");

        // R5: out-of-range word address
        i2c_start();
        wbyte({ID, 1'b0}, a); check(a == 1'b0, "R2", {7'b0, a}, 8'h00, "device ack");
        wbyte(8'h1A, a);      check(a == 1'b1, "R5", {7'b0, a}, 8'h01, "no ack on bad address");
        wbyte(8'hEE, a);      check(a == 1'b1, "R5", {7'b0, a}, 8'h01, "data ignored");
        i2c_stop();
        host_chk(5'd0, 8'h5A, "R5");
        do_read(1'b0, 8'h00, 1, "R5");

        // R11: STOP in the middle of a data byte
        i2c_start();
        wbyte({ID, 1'b0}, a);
        wbyte(8'h08, a);
        mptr = 8;
        send_bits(8'hC3, 4);
        i2c_stop();
        host_chk(5'd8, 8'h08, "R11");
        do_read(1'b0, 8'h00, 1, "R11");

        // R11: repeated START in the middle of a data byte
        i2c_start();
        wbyte({ID, 1'b0}, a);
        wbyte(8'h0A, a);
        mptr = 10;
        send_bits(8'hF0, 3);
        do_read(1'b0, 8'h00, 1, "R11");
        host_chk(5'd10, 8'h0A, "R11");

        tick(20);
        check(exp_q.size() == 0, "R9", 8'(exp_q.size()), 8'h00, "expected bytes left over");
        check(r10_bad == 0, "R10", 8'(r10_bad), 8'h00, "SDA moved while SCL high");
        finish_tb();
    end
endmodule